// File: doc/BRIEF.md
# External DMA Request Activation Sequencer

This block converts an active-low external DMA request pin into transfer-start requests for a single DMA channel. The pin passes through a synchronizer before any decision uses it. A mode register selects one of two sensing modes. In falling-edge mode a three-step handshake fires one request per pin activation: the sequencer arms, waits for the transfer engine, and then disarms until the pin returns high. In low-level mode a request fires on every cycle in which the pin is low and the engine can accept a transfer.

When the channel is enabled, the sequencer always starts from the armed state. The first activation after enable is therefore found by level, so a pin that is already low before the enable is accepted. A pending flag records each granted request until the engine acknowledges that the transfer has started. A module-stop gate refuses entry to the clock-stopped condition while the channel is enabled or an interrupt is outstanding. The mode configuration is held through the stop period.

Top module: `extreq_sequencer`

## Requirements
- R1: After reset, senseState is 0 (idle), and xferReq, reqPending and stopActive are all 0.
- R2: The pin is sampled through a two-flop synchronizer. A pin change set up just after a clock edge first affects senseState at the third following rising edge.
- R3: senseState codes are 0 = idle, 1 = armed, 2 = waiting for transfer, 3 = disarmed. With chanEnable high, idle goes to armed on the next edge. The armed state reacts to a synchronized low level, so a pin that is already low before enable leads to the waiting state one edge after arming (edge mode).
- R4: The mode register holds 0 for falling-edge mode and 1 for low-level mode. In falling-edge mode, armed goes to waiting on an edge where the synchronized pin is low, and otherwise stays armed.
- R5: In falling-edge mode, while waiting and xferPossible is high, xferReq is 1 in that same cycle and the state becomes disarmed on the next edge. While waiting with xferPossible low, xferReq is 0 and the state holds.
- R6: In falling-edge mode, the disarmed state stays put and produces no xferReq while the synchronized pin stays low. It returns to armed on the first edge that sees the synchronized pin high.
- R7: In low-level mode the state stays armed. xferReq is 1 in every cycle in which the channel is enabled, the state is armed, the synchronized pin is low and xferPossible is high, with no re-arm step between requests.
- R8: reqPending becomes 1 on the edge after a cycle with xferReq high. It is cleared on the edge after xferStarted is high in a cycle without xferReq; a new request wins over an acknowledge in the same cycle.
- R9: With chanEnable low, xferReq is 0, and on the next edge senseState becomes 0 and reqPending becomes 0.
- R10: A write of modeSel through modeWrEn takes effect only while chanEnable is low and the block is not stopped. Otherwise the write is ignored and the previous mode stays in force, including through a stop period.
- R11: stopActive rises on the edge after stopReq is high while chanEnable and irqPending are both low. It is refused while either of them is high, stays 1 while stopReq stays high, and clears on the edge after stopReq falls.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| reqPinN | input | 1 | External request pin, active low, asynchronous |
| chanEnable | input | 1 | Channel enabled for transfer |
| modeWrEn | input | 1 | Write strobe for the sensing mode |
| modeSel | input | 1 | Mode to write: 0 falling edge, 1 low level |
| xferPossible | input | 1 | Transfer engine can start a transfer |
| xferStarted | input | 1 | Transfer engine acknowledges a started transfer |
| irqPending | input | 1 | An interrupt request of the channel is outstanding |
| stopReq | input | 1 | Request to enter the module-stop condition |
| xferReq | output | 1 | Transfer-start request, valid in the current cycle |
| reqPending | output | 1 | A granted request is waiting for acknowledge |
| senseState | output | 2 | Current sensing state code |
| stopActive | output | 1 | Module-stop condition in force |

## Verification
Directed sequences try a pin that is already low before enable, a pin held low across a grant, and a pin that is released and lowered again. These patterns separate the level-sensed first activation from true edge re-arming, and they expose the three-edge synchronizer latency. A low-level run with xferPossible held high shows whether requests repeat with no re-arm. Its repeat after a mode write during operation shows whether that write was ignored. Stop requests are tried with enable high, with an interrupt pending, and with both clear, followed by long constrained-random stretches that toggle every input against a cycle model.

// File: rtl/extreq_pkg.sv
`timescale 1ns/1ps
package extreq_pkg;

  typedef enum logic [1:0] {
    SENSE_IDLE      = 2'd0,
    SENSE_ARMED     = 2'd1,
    SENSE_XFER_WAIT = 2'd2,
    SENSE_DISARMED  = 2'd3
  } senseState_e;

  typedef struct packed {
    logic grant;   // a transfer-start request is issued this cycle
    logic flush;   // channel disabled: drop all pending work
  } seqStrobes_t;

endpackage

// File: rtl/extreq_datapath.sv
`timescale 1ns/1ps
module extreq_datapath
  import extreq_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        reqPinN,
  input  logic        chanEnable,
  input  logic        modeWrEn,
  input  logic        modeSel,
  input  logic        xferStarted,
  input  logic        irqPending,
  input  logic        stopReq,
  input  seqStrobes_t strobes,
  output logic        pinLow,
  output logic        modeLevel,
  output logic        reqPending,
  output logic        stopActive
);

  localparam int LAST_STAGE = SYNC_STAGES - 1;

  logic [SYNC_STAGES-1:0] syncChain;

  // pin synchronizer, idle level is high
  generate
    if (SYNC_STAGES == 1) begin : g_syncSingle
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) syncChain <= '1;
        else       syncChain <= reqPinN;
      end
    end else begin : g_syncChain
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) syncChain <= '1;
        else       syncChain <= {syncChain[SYNC_STAGES-2:0], reqPinN};
      end
    end
  endgenerate

  assign pinLow = ~syncChain[LAST_STAGE];

  // mode register: writable only while idle and clocked
  logic modeWrOk;
  assign modeWrOk = modeWrEn && !chanEnable && !stopActive;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)         modeLevel <= 1'b0;
    else if (modeWrOk) modeLevel <= modeSel;
  end

  // pending request flag
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                reqPending <= 1'b0;
    else if (strobes.flush)   reqPending <= 1'b0;
    else if (strobes.grant)   reqPending <= 1'b1;
    else if (xferStarted)     reqPending <= 1'b0;
  end

  // module-stop gate
  logic stopAllowed;
  assign stopAllowed = !chanEnable && !irqPending;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) stopActive <= 1'b0;
    else       stopActive <= stopReq && (stopActive || stopAllowed);
  end

  // R8
  pend_set_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobes.grant |=> reqPending);

  // R8
  pend_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    (xferStarted && !strobes.grant) |=> !reqPending);

  // R11
  stop_refuse_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!stopActive && (chanEnable || irqPending)) |=> !stopActive);

  // R10
  mode_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (chanEnable || stopActive) |=> $stable(modeLevel));

endmodule

// File: rtl/extreq_control.sv
`timescale 1ns/1ps
module extreq_control
  import extreq_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        chanEnable,
  input  logic        xferPossible,
  input  logic        pinLow,
  input  logic        modeLevel,
  output seqStrobes_t strobes,
  output logic [1:0]  senseState,
  output logic        xferReq
);

  senseState_e stateQ, stateD;
  logic        grant;

  always_comb begin
    grant = 1'b0;
    if (chanEnable) begin
      if (modeLevel) grant = (stateQ == SENSE_ARMED) && pinLow && xferPossible;
      else           grant = (stateQ == SENSE_XFER_WAIT) && xferPossible;
    end
  end

  always_comb begin
    stateD = stateQ;
    if (!chanEnable) begin
      stateD = SENSE_IDLE;
    end else begin
      unique case (stateQ)
        SENSE_IDLE:      stateD = SENSE_ARMED;
        SENSE_ARMED:     stateD = (!modeLevel && pinLow) ? SENSE_XFER_WAIT : SENSE_ARMED;
        SENSE_XFER_WAIT: begin
          if (modeLevel)         stateD = SENSE_ARMED;
          else if (xferPossible) stateD = SENSE_DISARMED;
        end
        SENSE_DISARMED:  stateD = pinLow ? SENSE_DISARMED : SENSE_ARMED;
        default:         stateD = SENSE_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) stateQ <= SENSE_IDLE;
    else       stateQ <= stateD;
  end

  assign strobes.grant = grant;
  assign strobes.flush = !chanEnable;
  assign senseState    = stateQ;
  assign xferReq       = grant;

  // R9
  disable_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    !chanEnable |=> (senseState == 2'd0));

  // R5
  edge_disarm_chk: assert property (@(posedge clk) disable iff (!rstN)
    (xferReq && !modeLevel) |=> (senseState == 2'd3));

  // R6
  disarm_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (chanEnable && stateQ == SENSE_DISARMED && pinLow) |=> (senseState == 2'd3));

  // R7
  level_armed_chk: assert property (@(posedge clk) disable iff (!rstN)
    (chanEnable && modeLevel && stateQ == SENSE_ARMED) |=> (senseState == 2'd1 || senseState == 2'd0));

endmodule

// File: rtl/extreq_sequencer.sv
`timescale 1ns/1ps
module extreq_sequencer
  import extreq_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       reqPinN,
  input  logic       chanEnable,
  input  logic       modeWrEn,
  input  logic       modeSel,
  input  logic       xferPossible,
  input  logic       xferStarted,
  input  logic       irqPending,
  input  logic       stopReq,
  output logic       xferReq,
  output logic       reqPending,
  output logic [1:0] senseState,
  output logic       stopActive
);

  seqStrobes_t strobes;
  logic        pinLow;
  logic        modeLevel;

  extreq_datapath #(.SYNC_STAGES(SYNC_STAGES)) u_datapath (
    .clk         (clk),
    .rstN        (rstN),
    .reqPinN     (reqPinN),
    .chanEnable  (chanEnable),
    .modeWrEn    (modeWrEn),
    .modeSel     (modeSel),
    .xferStarted (xferStarted),
    .irqPending  (irqPending),
    .stopReq     (stopReq),
    .strobes     (strobes),
    .pinLow      (pinLow),
    .modeLevel   (modeLevel),
    .reqPending  (reqPending),
    .stopActive  (stopActive)
  );

  extreq_control u_control (
    .clk          (clk),
    .rstN         (rstN),
    .chanEnable   (chanEnable),
    .xferPossible (xferPossible),
    .pinLow       (pinLow),
    .modeLevel    (modeLevel),
    .strobes      (strobes),
    .senseState   (senseState),
    .xferReq      (xferReq)
  );

endmodule

// File: tb/test_extreq_sequencer.sv
`timescale 1ns/1ps
module test_extreq_sequencer;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic reqPinN = 1'b1, chanEnable = 1'b0, modeWrEn = 1'b0, modeSel = 1'b0;
  logic xferPossible = 1'b0, xferStarted = 1'b0, irqPending = 1'b0, stopReq = 1'b0;
  logic xferReq, reqPending, stopActive;
  logic [1:0] senseState;

  int testsRun = 0;
  int testsFailed = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  extreq_sequencer i_extreq_sequencer (
    .clk(clk), .rstN(rstN), .reqPinN(reqPinN), .chanEnable(chanEnable),
    .modeWrEn(modeWrEn), .modeSel(modeSel), .xferPossible(xferPossible),
    .xferStarted(xferStarted), .irqPending(irqPending), .stopReq(stopReq),
    .xferReq(xferReq), .reqPending(reqPending), .senseState(senseState),
    .stopActive(stopActive)
  );

  // cycle model built from the requirements
  logic [1:0] mSync = 2'b11;
  logic [1:0] mState = 2'd0;
  logic mMode = 1'b0, mPend = 1'b0, mStop = 1'b0;

  function automatic logic modelGrant();
    logic pl;
    pl = !mSync[1];
    if (!chanEnable) return 1'b0;
    if (mMode) return (mState == 2'd1) && pl && xferPossible;
    return (mState == 2'd2) && xferPossible;
  endfunction

  function automatic logic [1:0] modelNext();
    logic pl;
    pl = !mSync[1];
    if (!chanEnable) return 2'd0;
    case (mState)
      2'd0: return 2'd1;
      2'd1: return (!mMode && pl) ? 2'd2 : 2'd1;
      2'd2: return mMode ? 2'd1 : (xferPossible ? 2'd3 : 2'd2);
      default: return pl ? 2'd3 : 2'd1;
    endcase
  endfunction

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mSync = 2'b11; mState = 2'd0; mMode = 1'b0; mPend = 1'b0; mStop = 1'b0;
    end else begin
      logic g, nPend, nMode, nStop;
      logic [1:0] nState;
      g      = modelGrant();
      nState = modelNext();
      nPend  = !chanEnable ? 1'b0 : (g ? 1'b1 : (xferStarted ? 1'b0 : mPend));
      nMode  = (modeWrEn && !chanEnable && !mStop) ? modeSel : mMode;
      nStop  = stopReq && (mStop || (!chanEnable && !irqPending));
      mSync  = {mSync[0], reqPinN};
      mState = nState; mPend = nPend; mMode = nMode; mStop = nStop;
    end
  end

  task automatic chk(input string tag, input logic [1:0] act, input logic [1:0] exp);
    testsRun++;
    if (act !== exp) begin
      testsFailed++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic compareAll();
    chk("R3 R4 R5 R6 R7 R9 senseState", senseState, mState);
    chk("R5 R7 R9 xferReq", {1'b0, xferReq}, {1'b0, modelGrant()});
    chk("R8 R9 reqPending", {1'b0, reqPending}, {1'b0, mPend});
    chk("R11 stopActive", {1'b0, stopActive}, {1'b0, mStop});
  endtask

  task automatic step();
    @(posedge clk); #5;
    compareAll();
  endtask

  initial begin : watchdog
    #(200000 * 20);
    if (!finished) begin
      testsRun++; testsFailed++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
      $finish;
    end
  end

  initial begin : stim
    int seedDummy;
    seedDummy = $urandom(32'd24681);
    repeat (3) @(posedge clk);
    #5;
    // R1 reset state
    chk("R1 senseState", senseState, 2'd0);
    chk("R1 xferReq", {1'b0, xferReq}, 2'd0);
    chk("R1 reqPending", {1'b0, reqPending}, 2'd0);
    chk("R1 stopActive", {1'b0, stopActive}, 2'd0);
    rstN = 1'b1;

    // R3: pin already low before enable, edge mode
    reqPinN = 1'b0;
    repeat (3) step();
    chanEnable = 1'b1;
    step(); chk("R3 armed after enable", senseState, 2'd1);
    step(); chk("R3 level-sensed first activation", senseState, 2'd2);
    xferPossible = 1'b1; #2;
    chk("R5 request while waiting", {1'b0, xferReq}, 2'd1);
    step(); chk("R5 disarmed after grant", senseState, 2'd3);
    chk("R8 pending after grant", {1'b0, reqPending}, 2'd1);
    step(); step();
    chk("R6 held while pin low", senseState, 2'd3);
    chk("R6 no request while disarmed", {1'b0, xferReq}, 2'd0);
    xferPossible = 1'b0;
    reqPinN = 1'b1;
    step(); step();
    chk("R6 still disarmed before sync", senseState, 2'd3);
    step(); chk("R6 re-armed on high", senseState, 2'd1);

    // R2 latency, R4 arm to wait
    reqPinN = 1'b0;
    step(); step();
    chk("R2 no reaction before sync", senseState, 2'd1);
    step(); chk("R4 waiting after sync low", senseState, 2'd2);
    step(); chk("R5 waiting holds without engine", senseState, 2'd2);
    xferStarted = 1'b1;
    step(); chk("R8 ack clears pending", {1'b0, reqPending}, 2'd0);
    xferStarted = 1'b1; xferPossible = 1'b1; #2;
    step(); chk("R8 grant wins over ack", {1'b0, reqPending}, 2'd1);
    xferStarted = 1'b0; xferPossible = 1'b0;

    // R9 disable
    chanEnable = 1'b0; #2;
    chk("R9 no request while disabled", {1'b0, xferReq}, 2'd0);
    step(); chk("R9 idle after disable", senseState, 2'd0);
    chk("R9 pending cleared", {1'b0, reqPending}, 2'd0);

    // R7 low-level mode, R10 ignored write while enabled
    modeWrEn = 1'b1; modeSel = 1'b1;
    step(); modeWrEn = 1'b0;
    chanEnable = 1'b1; xferPossible = 1'b1;
    step(); #2; chk("R7 request in level mode", {1'b0, xferReq}, 2'd1);
    step(); chk("R7 repeat without re-arm", {1'b0, xferReq}, 2'd1);
    chk("R7 state stays armed", senseState, 2'd1);
    modeWrEn = 1'b1; modeSel = 1'b0;
    step(); modeWrEn = 1'b0;
    step(); chk("R10 mode write ignored when enabled", senseState, 2'd1);
    chk("R10 level requests continue", {1'b0, xferReq}, 2'd1);
    xferPossible = 1'b0;

    // R11 stop gate
    stopReq = 1'b1;
    step(); chk("R11 refused while enabled", {1'b0, stopActive}, 2'd0);
    chanEnable = 1'b0; irqPending = 1'b1;
    step(); step(); chk("R11 refused with irq", {1'b0, stopActive}, 2'd0);
    irqPending = 1'b0;
    step(); chk("R11 stop entered", {1'b0, stopActive}, 2'd1);
    modeWrEn = 1'b1; modeSel = 1'b0;
    step(); modeWrEn = 1'b0;
    stopReq = 1'b0;
    step(); chk("R11 stop left", {1'b0, stopActive}, 2'd0);
    chanEnable = 1'b1; xferPossible = 1'b1;
    step(); step(); chk("R10 mode kept through stop", {1'b0, xferReq}, 2'd1);
    chk("R10 state armed in level mode", senseState, 2'd1);

    // constrained random against the model
    for (int i = 0; i < 5000; i++) begin
      if ($urandom_range(5) == 0)  reqPinN = ~reqPinN;
      if ($urandom_range(24) == 0) chanEnable = ~chanEnable;
      modeWrEn     = ($urandom_range(9) == 0);
      modeSel      = $urandom_range(1);
      xferPossible = $urandom_range(1);
      xferStarted  = ($urandom_range(3) == 0);
      if ($urandom_range(7) == 0)  irqPending = ~irqPending;
      if ($urandom_range(11) == 0) stopReq = ~stopReq;
      #2; compareAll();
      step();
    end

    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

endmodule